// File: doc/BRIEF.md
# Trap Entry Router with Nested-Trap Escalation

This block decides, for every trap a hart takes, which privilege level handles it (supervisor, virtual supervisor or machine) and computes the status and target values written on entry. Its inputs are the trap cause, the interrupt/exception flag, the current privilege and virtualization state, the delegation and injection inputs, and the current interrupt-enable and nested-trap status bits. It returns the target mode, the next values of the status fields, the cause word, the secondary trap value, the handler PC, and flags for non-maskable escalation and fatal halt.

Nested traps are detected on entry. Suppose a supervisor handler is still marked "in trap" and the nested-trap feature is enabled at the relevant level. A second trap that would land in that handler is redirected to machine mode instead. It is reported with a dedicated cause code, and the original cause is saved as the secondary trap value. A trap that reaches machine mode while the machine "in trap" bit is still set has two outcomes. It is escalated to a non-maskable interrupt if that feature exists and the trap is not itself a non-maskable exception. Otherwise it halts the hart.

The block registers its results. One cycle after `trap_valid`, `out_valid` pulses and all result outputs hold the decision for that trap until the next one. Privilege encoding: 0 = user, 1 = supervisor, 3 = machine.

Top module: `trap_entry_arb`

## Requirements
- R1: The target is supervisor (`tgt_mode` = 1) only when `cur_priv` is 0 or 1, the cause is below 64, and the cause bit of the delegation mask (the interrupt mask when `trap_async`=1, the exception mask otherwise) is 1 or either inject input is 1. Otherwise the target is machine (`tgt_mode` = 3).
- R2: `tgt_virt` is 1 only for a supervisor target taken with `cur_virt`=1 where the hypervisor delegation bit for the cause is 1 or `vs_inject` is 1. Any machine target gives `tgt_virt`=0.
- R3: The supervisor nested-trap check applies only when `sdbl_feature`=1, `cur_priv`=1 and R1 picks supervisor. It fires when enable and in-trap bit are both 1. The enable is `h_dbl_en` for a virtual-to-virtual trap and `m_dbl_en` otherwise. The in-trap bit is `st_sdt_hs` for a trap from virtual mode into the host supervisor, and `st_sdt` otherwise.
- R4: When the R3 check fires, the target becomes machine, `cause_out` = 16, and `tval2_out` holds the cause word that would otherwise have been reported. For any other trap, `tval2_out` is 0.
- R5: On supervisor entry, `nx_spie` gets `st_sie`, `nx_spp` gets bit 0 of `cur_priv`, and `nx_sie` is 0. `nx_sdt` becomes 1 when the target level's enable is 1 (`h_dbl_en` if `tgt_virt`, else `m_dbl_en`); otherwise `nx_sdt` keeps `st_sdt`.
- R6: On ordinary machine entry, `nx_mpie` gets `st_mie`, `nx_mpp` gets `cur_priv`, and `nx_mie` is 0. `nx_mdt` becomes 1 when `mdbl_feature`=1.
- R7: A machine target with `mdbl_feature`=1 and `st_mdt`=1 raises `halt_out` when `nmi_feature`=0, or when the trap is a non-maskable exception (see R10). Otherwise it raises `nmi_out`, with `pc_out` = `nmi_vec` and `cause_out` equal to the bare cause (top bit 0). `halt_out` and `nmi_out` are never both 1.
- R8: For normal entries, `cause_out` holds the cause zero-extended, with bit XLEN-1 set to `trap_async`.
- R9: The handler PC is the target tvec with its two low bits cleared (`vstvec` for virtual supervisor, `stvec` for supervisor, `mtvec` for machine). 4×cause is added only when `trap_async`=1 and the tvec low bits equal 1.
- R10: A non-maskable exception is a synchronous trap to machine mode with `nmi_feature`=1 and `nmi_enable`=0. Unless R7 applies, it sets `pc_out` to `nmi_exc_vec`. Asynchronous traps in that state use R9.
- R11: `out_valid` is 1 exactly one cycle after `trap_valid`. After reset, `out_valid`, `halt_out` and `nmi_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| trap_valid | input | 1 | A trap is presented this cycle |
| trap_async | input | 1 | 1 = interrupt, 0 = exception |
| trap_cause | input | CAUSE_W | Cause number |
| cur_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| cur_virt | input | 1 | Current virtualization state |
| m_exc_deleg | input | DELEG_W | Machine exception delegation mask |
| m_irq_deleg | input | DELEG_W | Machine interrupt delegation mask |
| h_exc_deleg | input | DELEG_W | Hypervisor exception delegation mask |
| h_irq_deleg | input | DELEG_W | Hypervisor interrupt delegation mask |
| s_inject | input | 1 | Supervisor-injected interrupt |
| vs_inject | input | 1 | Virtual-supervisor-injected interrupt |
| sdbl_feature | input | 1 | Supervisor nested-trap feature present |
| mdbl_feature | input | 1 | Machine nested-trap feature present |
| nmi_feature | input | 1 | Resumable NMI feature present |
| nmi_enable | input | 1 | NMIs currently enabled |
| m_dbl_en | input | 1 | Supervisor nested-trap enable, machine config |
| h_dbl_en | input | 1 | Supervisor nested-trap enable, hypervisor config |
| st_sie | input | 1 | Current supervisor interrupt enable |
| st_spie | input | 1 | Current supervisor previous enable |
| st_spp | input | 1 | Current supervisor previous privilege |
| st_sdt | input | 1 | Current supervisor in-trap bit |
| st_sdt_hs | input | 1 | Host-supervisor copy of the in-trap bit |
| st_mie | input | 1 | Current machine interrupt enable |
| st_mpie | input | 1 | Current machine previous enable |
| st_mpp | input | 2 | Current machine previous privilege |
| st_mdt | input | 1 | Current machine in-trap bit |
| stvec | input | XLEN | Supervisor trap vector |
| vstvec | input | XLEN | Virtual supervisor trap vector |
| mtvec | input | XLEN | Machine trap vector |
| nmi_vec | input | XLEN | NMI handler address |
| nmi_exc_vec | input | XLEN | NMI exception handler address |
| out_valid | output | 1 | Result valid pulse |
| tgt_mode | output | 2 | Target privilege |
| tgt_virt | output | 1 | Target virtualization state |
| nx_sie | output | 1 | Next supervisor interrupt enable |
| nx_spie | output | 1 | Next supervisor previous enable |
| nx_spp | output | 1 | Next supervisor previous privilege |
| nx_sdt | output | 1 | Next supervisor in-trap bit |
| nx_mie | output | 1 | Next machine interrupt enable |
| nx_mpie | output | 1 | Next machine previous enable |
| nx_mpp | output | 2 | Next machine previous privilege |
| nx_mdt | output | 1 | Next machine in-trap bit |
| cause_out | output | XLEN | Cause word to record |
| tval2_out | output | XLEN | Secondary trap value |
| pc_out | output | XLEN | Handler PC |
| halt_out | output | 1 | Fatal halt |
| nmi_out | output | 1 | Escalated to NMI |

## Verification
On every result pulse, the assertions check several invariants. A machine target never keeps virtualization. Halt and NMI escalation never coincide, and a halt always names machine mode. A supervisor target was reached from user or supervisor and clears the supervisor enable. A supervisor nested trap always reports cause 16 at machine level. `out_valid` follows `trap_valid` by one cycle. The bench scenarios alone show the choices that depend on exact input combinations: which enable and which in-trap copy are consulted for virtual-to-virtual and virtual-to-host traps, the vectored offset arithmetic, the cause and secondary-value words, and which of halt, NMI or the NMI-exception vector applies.

// File: rtl/trap_arb_pkg.sv
package trap_arb_pkg;
  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;
  localparam int unsigned NESTED_TRAP_CODE = 16;

  typedef struct packed {
    logic to_s;    // delegation picks supervisor
    logic vs_exc;  // virtual-to-virtual routing
    logic sdbl;    // supervisor nested trap detected
  } route_t;
endpackage

// File: rtl/trap_route.sv
module trap_route
  import trap_arb_pkg::*;
#(
  parameter int CAUSE_W = 8,
  parameter int DELEG_W = 64
) (
  input  logic               is_async,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [1:0]         priv,
  input  logic               virt,
  input  logic [DELEG_W-1:0] m_exc_deleg,
  input  logic [DELEG_W-1:0] m_irq_deleg,
  input  logic [DELEG_W-1:0] h_exc_deleg,
  input  logic [DELEG_W-1:0] h_irq_deleg,
  input  logic               s_inject,
  input  logic               vs_inject,
  input  logic               sdbl_feature,
  input  logic               m_dbl_en,
  input  logic               h_dbl_en,
  input  logic               sdt,
  input  logic               sdt_hs,
  output route_t             rt
);
  localparam int IDX_W = $clog2(DELEG_W);

  logic             in_range;
  logic [IDX_W-1:0] idx;
  logic             m_bit, h_bit;
  logic             dte_sel, sdt_sel;

  always_comb begin
    in_range = ({1'b0, cause} < (CAUSE_W+1)'(DELEG_W));
    idx      = cause[IDX_W-1:0];
    m_bit    = in_range && (is_async ? m_irq_deleg[idx] : m_exc_deleg[idx]);
    h_bit    = in_range && (is_async ? h_irq_deleg[idx] : h_exc_deleg[idx]);

    rt.to_s   = (priv == PRIV_U || priv == PRIV_S) && in_range &&
                (m_bit || s_inject || vs_inject);
    rt.vs_exc = virt && (h_bit || vs_inject);

    dte_sel = rt.vs_exc ? h_dbl_en : m_dbl_en;
    sdt_sel = (virt && !rt.vs_exc) ? sdt_hs : sdt;
    rt.sdbl = sdbl_feature && (priv == PRIV_S) && rt.to_s && dte_sel && sdt_sel;
  end
endmodule

// File: rtl/trap_status.sv
module trap_status
  import trap_arb_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int CAUSE_W = 8
) (
  input  route_t             rt,
  input  logic               is_async,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [1:0]         priv,
  input  logic               mdbl_feature,
  input  logic               nmi_feature,
  input  logic               nmi_enable,
  input  logic               m_dbl_en,
  input  logic               h_dbl_en,
  input  logic               st_sie,
  input  logic               st_spie,
  input  logic               st_spp,
  input  logic               st_sdt,
  input  logic               st_mie,
  input  logic               st_mpie,
  input  logic [1:0]         st_mpp,
  input  logic               st_mdt,
  input  logic [XLEN-1:0]    stvec,
  input  logic [XLEN-1:0]    vstvec,
  input  logic [XLEN-1:0]    mtvec,
  input  logic [XLEN-1:0]    nmi_vec,
  input  logic [XLEN-1:0]    nmi_exc_vec,
  output logic [1:0]         mode,
  output logic               virt_o,
  output logic               sie_o,
  output logic               spie_o,
  output logic               spp_o,
  output logic               sdt_o,
  output logic               mie_o,
  output logic               mpie_o,
  output logic [1:0]         mpp_o,
  output logic               mdt_o,
  output logic [XLEN-1:0]    cause_o,
  output logic [XLEN-1:0]    tval2_o,
  output logic [XLEN-1:0]    pc_o,
  output logic               halt_o,
  output logic               nmi_o
);
  function automatic logic [XLEN-1:0] cause_word(input logic a, input logic [CAUSE_W-1:0] c);
    logic [XLEN-1:0] w;
    w = '0;
    w[CAUSE_W-1:0] = c;
    w[XLEN-1] = a;
    return w;
  endfunction

  function automatic logic [XLEN-1:0] vec_pc(input logic [XLEN-1:0] tvec, input logic a,
                                             input logic [CAUSE_W-1:0] c);
    logic [XLEN-1:0] base, off;
    base = {tvec[XLEN-1:2], 2'b00};
    off  = (a && tvec[1:0] == 2'b01) ? (XLEN'(c) << 2) : '0;
    return base + off;
  endfunction

  logic s_final, m_nested, nmi_exc;

  always_comb begin
    s_final  = rt.to_s && !rt.sdbl;
    m_nested = !s_final && mdbl_feature && st_mdt;
    nmi_exc  = nmi_feature && !nmi_enable && !is_async;

    mode    = PRIV_M;
    virt_o  = 1'b0;
    sie_o   = st_sie;
    spie_o  = st_spie;
    spp_o   = st_spp;
    sdt_o   = st_sdt;
    mie_o   = st_mie;
    mpie_o  = st_mpie;
    mpp_o   = st_mpp;
    mdt_o   = st_mdt;
    cause_o = cause_word(is_async, cause);
    tval2_o = '0;
    pc_o    = '0;
    halt_o  = 1'b0;
    nmi_o   = 1'b0;

    if (s_final) begin
      mode   = PRIV_S;
      virt_o = rt.vs_exc;
      spie_o = st_sie;
      spp_o  = priv[0];
      sie_o  = 1'b0;
      if (rt.vs_exc ? h_dbl_en : m_dbl_en) sdt_o = 1'b1;
      pc_o   = vec_pc(rt.vs_exc ? vstvec : stvec, is_async, cause);
    end else if (m_nested) begin
      if (!nmi_feature || nmi_exc) begin
        halt_o = 1'b1;
      end else begin
        nmi_o   = 1'b1;
        cause_o = cause_word(1'b0, cause);
        pc_o    = nmi_vec;
      end
    end else begin
      mpie_o = st_mie;
      mpp_o  = priv;
      mie_o  = 1'b0;
      if (mdbl_feature) mdt_o = 1'b1;
      if (rt.sdbl) begin
        tval2_o = cause_word(is_async, cause);
        cause_o = XLEN'(NESTED_TRAP_CODE);
      end
      pc_o = nmi_exc ? nmi_exc_vec : vec_pc(mtvec, is_async, cause);
    end
  end
endmodule

// File: rtl/trap_entry_arb.sv
module trap_entry_arb
  import trap_arb_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int CAUSE_W = 8,
  parameter int DELEG_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_valid,
  input  logic               trap_async,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [1:0]         cur_priv,
  input  logic               cur_virt,
  input  logic [DELEG_W-1:0] m_exc_deleg,
  input  logic [DELEG_W-1:0] m_irq_deleg,
  input  logic [DELEG_W-1:0] h_exc_deleg,
  input  logic [DELEG_W-1:0] h_irq_deleg,
  input  logic               s_inject,
  input  logic               vs_inject,
  input  logic               sdbl_feature,
  input  logic               mdbl_feature,
  input  logic               nmi_feature,
  input  logic               nmi_enable,
  input  logic               m_dbl_en,
  input  logic               h_dbl_en,
  input  logic               st_sie,
  input  logic               st_spie,
  input  logic               st_spp,
  input  logic               st_sdt,
  input  logic               st_sdt_hs,
  input  logic               st_mie,
  input  logic               st_mpie,
  input  logic [1:0]         st_mpp,
  input  logic               st_mdt,
  input  logic [XLEN-1:0]    stvec,
  input  logic [XLEN-1:0]    vstvec,
  input  logic [XLEN-1:0]    mtvec,
  input  logic [XLEN-1:0]    nmi_vec,
  input  logic [XLEN-1:0]    nmi_exc_vec,
  output logic               out_valid,
  output logic [1:0]         tgt_mode,
  output logic               tgt_virt,
  output logic               nx_sie,
  output logic               nx_spie,
  output logic               nx_spp,
  output logic               nx_sdt,
  output logic               nx_mie,
  output logic               nx_mpie,
  output logic [1:0]         nx_mpp,
  output logic               nx_mdt,
  output logic [XLEN-1:0]    cause_out,
  output logic [XLEN-1:0]    tval2_out,
  output logic [XLEN-1:0]    pc_out,
  output logic               halt_out,
  output logic               nmi_out
);
  route_t          rt;
  logic [1:0]      c_mode, c_mpp;
  logic            c_virt, c_sie, c_spie, c_spp, c_sdt, c_mie, c_mpie, c_mdt;
  logic            c_halt, c_nmi;
  logic [XLEN-1:0] c_cause, c_tval2, c_pc;
  logic            sdbl_q;  // registered nested-trap event for the checker

  trap_route #(.CAUSE_W(CAUSE_W), .DELEG_W(DELEG_W)) u_route (
    .is_async(trap_async), .cause(trap_cause), .priv(cur_priv), .virt(cur_virt),
    .m_exc_deleg(m_exc_deleg), .m_irq_deleg(m_irq_deleg),
    .h_exc_deleg(h_exc_deleg), .h_irq_deleg(h_irq_deleg),
    .s_inject(s_inject), .vs_inject(vs_inject), .sdbl_feature(sdbl_feature),
    .m_dbl_en(m_dbl_en), .h_dbl_en(h_dbl_en), .sdt(st_sdt), .sdt_hs(st_sdt_hs),
    .rt(rt)
  );

  trap_status #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_status (
    .rt(rt), .is_async(trap_async), .cause(trap_cause), .priv(cur_priv),
    .mdbl_feature(mdbl_feature), .nmi_feature(nmi_feature), .nmi_enable(nmi_enable),
    .m_dbl_en(m_dbl_en), .h_dbl_en(h_dbl_en),
    .st_sie(st_sie), .st_spie(st_spie), .st_spp(st_spp), .st_sdt(st_sdt),
    .st_mie(st_mie), .st_mpie(st_mpie), .st_mpp(st_mpp), .st_mdt(st_mdt),
    .stvec(stvec), .vstvec(vstvec), .mtvec(mtvec),
    .nmi_vec(nmi_vec), .nmi_exc_vec(nmi_exc_vec),
    .mode(c_mode), .virt_o(c_virt), .sie_o(c_sie), .spie_o(c_spie), .spp_o(c_spp),
    .sdt_o(c_sdt), .mie_o(c_mie), .mpie_o(c_mpie), .mpp_o(c_mpp), .mdt_o(c_mdt),
    .cause_o(c_cause), .tval2_o(c_tval2), .pc_o(c_pc), .halt_o(c_halt), .nmi_o(c_nmi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      tgt_mode  <= PRIV_M;
      tgt_virt  <= 1'b0;
      nx_sie    <= 1'b0;
      nx_spie   <= 1'b0;
      nx_spp    <= 1'b0;
      nx_sdt    <= 1'b0;
      nx_mie    <= 1'b0;
      nx_mpie   <= 1'b0;
      nx_mpp    <= 2'b00;
      nx_mdt    <= 1'b0;
      cause_out <= '0;
      tval2_out <= '0;
      pc_out    <= '0;
      halt_out  <= 1'b0;
      nmi_out   <= 1'b0;
      sdbl_q    <= 1'b0;
    end else begin
      out_valid <= trap_valid;
      if (trap_valid) begin
        tgt_mode  <= c_mode;
        tgt_virt  <= c_virt;
        nx_sie    <= c_sie;
        nx_spie   <= c_spie;
        nx_spp    <= c_spp;
        nx_sdt    <= c_sdt;
        nx_mie    <= c_mie;
        nx_mpie   <= c_mpie;
        nx_mpp    <= c_mpp;
        nx_mdt    <= c_mdt;
        cause_out <= c_cause;
        tval2_out <= c_tval2;
        pc_out    <= c_pc;
        halt_out  <= c_halt;
        nmi_out   <= c_nmi;
        sdbl_q    <= rt.sdbl;
      end
    end
  end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trap_valid,
  input logic [1:0]      cur_priv,
  input logic            out_valid,
  input logic [1:0]      tgt_mode,
  input logic            tgt_virt,
  input logic            nx_sie,
  input logic            halt_out,
  input logic            nmi_out,
  input logic [XLEN-1:0] cause_out,
  input logic            sdbl_q
);
  // R11
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> out_valid);
  // R11
  valid_only_after_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid |=> !out_valid);
  // R2
  m_target_no_virt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && tgt_mode == 2'b11) |-> !tgt_virt);
  // R7
  halt_nmi_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(halt_out && nmi_out));
  // R7
  halt_in_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && halt_out) |-> tgt_mode == 2'b11);
  // R1
  s_from_low_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && cur_priv == 2'b11) |=> tgt_mode == 2'b11);
  // R5
  s_entry_sie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && tgt_mode == 2'b01) |-> !nx_sie);
  // R4
  nested_s_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sdbl_q && !halt_out && !nmi_out) |->
      (tgt_mode == 2'b11 && cause_out == XLEN'(16)));
endmodule

bind trap_entry_arb trap_entry_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .cur_priv(cur_priv),
  .out_valid(out_valid), .tgt_mode(tgt_mode), .tgt_virt(tgt_virt), .nx_sie(nx_sie),
  .halt_out(halt_out), .nmi_out(nmi_out), .cause_out(cause_out), .sdbl_q(sdbl_q)
);

// File: tb/tb_trap_entry_arb.sv
`timescale 1ns/1ps
module tb_trap_entry_arb;
  localparam int XLEN = 64;
  localparam int CW = 8;
  localparam int DW = 64;
  localparam logic [63:0] TOP = 64'h8000_0000_0000_0000;

  logic clk = 0, rst_n = 0;
  logic trap_valid, trap_async, cur_virt, s_inject, vs_inject;
  logic [CW-1:0] trap_cause;
  logic [1:0] cur_priv, st_mpp;
  logic [DW-1:0] m_exc_deleg, m_irq_deleg, h_exc_deleg, h_irq_deleg;
  logic sdbl_feature, mdbl_feature, nmi_feature, nmi_enable, m_dbl_en, h_dbl_en;
  logic st_sie, st_spie, st_spp, st_sdt, st_sdt_hs, st_mie, st_mpie, st_mdt;
  logic [XLEN-1:0] stvec, vstvec, mtvec, nmi_vec, nmi_exc_vec;
  logic out_valid, tgt_virt, nx_sie, nx_spie, nx_spp, nx_sdt, nx_mie, nx_mpie, nx_mdt;
  logic halt_out, nmi_out;
  logic [1:0] tgt_mode, nx_mpp;
  logic [XLEN-1:0] cause_out, tval2_out, pc_out;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trap_entry_arb #(.XLEN(XLEN), .CAUSE_W(CW), .DELEG_W(DW)) dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic defaults();
    trap_valid = 0; trap_async = 0; trap_cause = '0; cur_priv = 2'b00; cur_virt = 0;
    m_exc_deleg = '0; m_irq_deleg = '0; h_exc_deleg = '0; h_irq_deleg = '0;
    s_inject = 0; vs_inject = 0; sdbl_feature = 0; mdbl_feature = 0;
    nmi_feature = 0; nmi_enable = 1; m_dbl_en = 0; h_dbl_en = 0;
    st_sie = 1; st_spie = 0; st_spp = 0; st_sdt = 0; st_sdt_hs = 0;
    st_mie = 1; st_mpie = 0; st_mpp = 2'b00; st_mdt = 0;
    stvec = 64'h1001; vstvec = 64'h3000; mtvec = 64'h2001;
    nmi_vec = 64'h4000; nmi_exc_vec = 64'h5000;
  endtask

  task automatic fire();
    @(negedge clk) trap_valid = 1;
    @(negedge clk) trap_valid = 0;
    chk("R11 valid", {63'd0, out_valid}, 64'd1);
  endtask

  task automatic t_reset();
    chk("R11 reset valid", {63'd0, out_valid}, 0);
    chk("R11 reset halt", {63'd0, halt_out}, 0);
    chk("R11 reset nmi", {63'd0, nmi_out}, 0);
  endtask

  task automatic t_user_deleg();
    defaults(); trap_cause = 8; m_exc_deleg[8] = 1; fire();
    chk("R1 mode", {62'd0, tgt_mode}, 1);
    chk("R5 spie", {63'd0, nx_spie}, 1);
    chk("R5 sie", {63'd0, nx_sie}, 0);
    chk("R5 spp", {63'd0, nx_spp}, 0);
    chk("R8 cause", cause_out, 8);
    chk("R9 sync pc", pc_out, 64'h1000);
    chk("R4 tval2 zero", tval2_out, 0);
  endtask

  task automatic t_user_m();
    defaults(); trap_cause = 8; fire();
    chk("R1 mode", {62'd0, tgt_mode}, 3);
    chk("R6 mpie", {63'd0, nx_mpie}, 1);
    chk("R6 mie", {63'd0, nx_mie}, 0);
    chk("R6 mpp", {62'd0, nx_mpp}, 0);
    chk("R6 mdt no feature", {63'd0, nx_mdt}, 0);
    chk("R9 m pc", pc_out, 64'h2000);
  endtask

  task automatic t_big_cause();
    defaults(); cur_priv = 2'b01; trap_async = 1; trap_cause = 70; s_inject = 1; fire();
    chk("R1 cause>=64 to M", {62'd0, tgt_mode}, 3);
    chk("R8 async bit", cause_out, TOP | 64'd70);
    chk("R9 vectored", pc_out, 64'h2118);
    chk("R6 mpp", {62'd0, nx_mpp}, 1);
  endtask

  task automatic t_irq_s();
    defaults(); trap_async = 1; trap_cause = 5; m_irq_deleg[5] = 1; fire();
    chk("R1 irq deleg", {62'd0, tgt_mode}, 1);
    chk("R8 async cause", cause_out, TOP | 64'd5);
    chk("R9 s vectored", pc_out, 64'h1014);
  endtask

  task automatic t_vs();
    defaults(); cur_priv = 2'b01; cur_virt = 1; trap_cause = 8;
    m_exc_deleg[8] = 1; h_exc_deleg[8] = 1; sdbl_feature = 1; h_dbl_en = 1; fire();
    chk("R2 virt", {63'd0, tgt_virt}, 1);
    chk("R2 mode", {62'd0, tgt_mode}, 1);
    chk("R9 vstvec", pc_out, 64'h3000);
    chk("R5 sdt set", {63'd0, nx_sdt}, 1);
    chk("R5 spp", {63'd0, nx_spp}, 1);
  endtask

  task automatic t_s_nested();
    defaults(); cur_priv = 2'b01; trap_cause = 8; m_exc_deleg[8] = 1;
    sdbl_feature = 1; m_dbl_en = 1; st_sdt = 1; fire();
    chk("R3 to M", {62'd0, tgt_mode}, 3);
    chk("R4 cause 16", cause_out, 16);
    chk("R4 tval2", tval2_out, 8);
    chk("R4 mpp", {62'd0, nx_mpp}, 1);
  endtask

  task automatic t_vs_vs_henable();
    defaults(); cur_priv = 2'b01; cur_virt = 1; trap_cause = 8;
    m_exc_deleg[8] = 1; h_exc_deleg[8] = 1; sdbl_feature = 1;
    m_dbl_en = 1; h_dbl_en = 0; st_sdt = 1; fire();
    chk("R3 vs-vs uses h enable", {62'd0, tgt_mode}, 1);
    chk("R2 stays virt", {63'd0, tgt_virt}, 1);
    chk("R5 sdt kept", {63'd0, nx_sdt}, 1);
  endtask

  task automatic t_vs_hs();
    defaults(); cur_priv = 2'b01; cur_virt = 1; trap_cause = 8;
    m_exc_deleg[8] = 1; sdbl_feature = 1; m_dbl_en = 1; st_sdt = 0; st_sdt_hs = 1; fire();
    chk("R3 hs copy", {62'd0, tgt_mode}, 3);
    chk("R4 cause 16", cause_out, 16);
    chk("R2 virt cleared", {63'd0, tgt_virt}, 0);
  endtask

  task automatic t_user_no_nested();
    defaults(); trap_cause = 8; m_exc_deleg[8] = 1; sdbl_feature = 1; m_dbl_en = 1;
    st_sdt = 1; fire();
    chk("R3 only from S", {62'd0, tgt_mode}, 1);
    chk("R3 cause", cause_out, 8);
  endtask

  task automatic t_m_nested(input logic nf, input logic ne, input logic eh,
                            input logic en, input string tag);
    defaults(); cur_priv = 2'b11; trap_cause = 2; mdbl_feature = 1; st_mdt = 1;
    nmi_feature = nf; nmi_enable = ne; fire();
    chk({"R7 halt ", tag}, {63'd0, halt_out}, {63'd0, eh});
    chk({"R7 nmi ", tag}, {63'd0, nmi_out}, {63'd0, en});
    if (en) begin
      chk("R7 nmi pc", pc_out, 64'h4000);
      chk("R7 nmi cause", cause_out, 2);
    end
  endtask

  task automatic t_nmi_exc(input logic as, input logic [63:0] exp_pc, input string tag);
    defaults(); cur_priv = 2'b11; trap_async = as; trap_cause = as ? 8'd7 : 8'd2;
    nmi_feature = 1; nmi_enable = 0; mdbl_feature = 1; st_mpp = 2'b00; fire();
    chk({"R10 pc ", tag}, pc_out, exp_pc);
    chk("R6 mdt set", {63'd0, nx_mdt}, 1);
    chk("R6 mpp", {62'd0, nx_mpp}, 3);
    chk("R7 no halt", {63'd0, halt_out}, 0);
  endtask

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_user_deleg();
    t_user_m();
    t_big_cause();
    t_irq_s();
    t_vs();
    t_s_nested();
    t_vs_vs_henable();
    t_vs_hs();
    t_user_no_nested();
    t_m_nested(1'b0, 1'b1, 1'b1, 1'b0, "no nmi feature");
    t_m_nested(1'b1, 1'b1, 1'b0, 1'b1, "escalate");
    t_m_nested(1'b1, 1'b0, 1'b1, 1'b0, "nmi exception");
    t_nmi_exc(1'b0, 64'h5000, "sync");
    t_nmi_exc(1'b1, 64'h201C, "async");
    @(negedge clk);
    chk("R11 idle valid", {63'd0, out_valid}, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule